// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses for a single read or write burst to a four-bank double-data-rate mobile memory. A controller presents a start column, a burst length code and an ordering mode, and pulses a start strobe. Data moves on both clock edges with a two-beat prefetch, so the block hands out one pair of column addresses per clock: the even beat and the odd beat of that clock. It flags the pair that carries the final beat and then goes quiet until the next start.

A burst can be cut short by a burst-stop or a precharge request. Either request, when seen on a clock where a pair is presented and that pair is not already the final one, makes the following pair the last one. A new start can follow the final pair of a burst with no idle clock in between. A start arriving in the middle of a burst is dropped.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is asserted and on the first clock after it is released with no start, `valid_o` and `last_o` are 0.
- R2: A start sampled at a rising edge while no burst is running makes `valid_o` 1 on the clock that follows, presenting beats 0 and 1 of the new burst on `col_even_o` and `col_odd_o`.
- R3: With `ilv_i` = 0 (sequential), beat i carries column bits [L-1:0] equal to (start low bits + i) mod BL, where L = log2(BL); the bits from L upward equal those of the start column.
- R4: With `ilv_i` = 1 (interleaved), beat i carries the start column XOR i, which changes only bits [L-1:0].
- R5: A burst that is not cut short presents BL/2 consecutive pairs with `valid_o` 1. `last_o` is 1 only on the final pair, and without a new start `valid_o` is 0 on the next clock.
- R6: `bl_code_i` selects the burst length: 0 gives 2 beats, 1 gives 4, 2 gives 8, 3 gives 16. The code and mode are captured with the start and held for the whole burst.
- R7: If `bst_i` or `pre_i` is 1 at a rising edge while a non-final pair is presented, the pair presented next is in normal order, carries `last_o` = 1, and `valid_o` is 0 on the clock after that.
- R8: A start sampled while a non-final pair is presented is ignored: the running burst continues unchanged.
- R9: A start sampled while the final pair (normal or early) is presented is accepted: the first pair of the new burst follows on the next clock with no gap.
- R10: `bst_i` and `pre_i` have no effect while no burst is running: `valid_o` stays 0.
- R11: `last_o` is never 1 while `valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe for a new burst |
| start_col_i | input | COL_W (10) | First column of the burst |
| bl_code_i | input | 2 | Burst length code (0:2, 1:4, 2:8, 3:16 beats) |
| ilv_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| bst_i | input | 1 | Burst-stop request |
| pre_i | input | 1 | Precharge request |
| col_even_o | output | COL_W (10) | Column of the even beat of the current pair |
| col_odd_o | output | COL_W (10) | Column of the odd beat of the current pair |
| valid_o | output | 1 | A pair is presented this clock |
| last_o | output | 1 | The presented pair carries the final beat |

## Verification
The assertions watch, on every clock, the handshake shape of a burst: last only with valid, valid held until last, valid dropping after last unless restarted, a start from idle opening a burst, idle staying idle under stop or precharge, an early stop turning the next pair into the last, and the two beats of a pair sharing the upper column bits. The exact beat order for each length and mode, the wrap point inside the aligned block, the capture of length and mode at start, a dropped mid-burst start and the gapless chaining of bursts all need known stimulus. Only the bench's scenarios, compared pair by pair against independently computed columns, show these.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

    // burst length encodings on bl_code_i
    typedef enum logic [1:0] {
        BLC_2  = 2'd0,
        BLC_4  = 2'd1,
        BLC_8  = 2'd2,
        BLC_16 = 2'd3
    } blc_e;

    // ordering mode
    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } ord_e;

    // number of low column bits that rotate for a given length code
    function automatic int unsigned rot_bits(input logic [1:0] code);
        return int'(code) + 1;
    endfunction

endpackage

// File: rtl/bsq_beat_addr.sv
// Column for one beat of a burst, from the captured start column,
// length code, ordering and beat index.
module bsq_beat_addr
    import bsq_pkg::*;
#(
    parameter int COL_W  = 10,
    parameter int BEAT_W = 4
) (
    input  logic [COL_W-1:0]  base_i,
    input  logic [1:0]        code_i,
    input  logic              ilv_i,
    input  logic [BEAT_W-1:0] beat_i,
    output logic [COL_W-1:0]  col_o
);
    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] beat_ext;
    logic [COL_W-1:0] sum;

    always_comb begin
        mask     = (COL_W'(1) << rot_bits(code_i)) - COL_W'(1);
        beat_ext = COL_W'(beat_i) & mask;
        sum      = base_i + beat_ext;
        if (ord_e'(ilv_i) == ORD_ILV) begin
            col_o = base_i ^ beat_ext;
        end else begin
            col_o = (base_i & ~mask) | (sum & mask);
        end
    end
endmodule

// File: rtl/bsq_ctrl.sv
// Burst control: captures the request, steps the pair index, handles
// early stop and chained starts.
module bsq_ctrl #(
    parameter int COL_W  = 10,
    parameter int PAIR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [COL_W-1:0]  start_col_i,
    input  logic [1:0]        bl_code_i,
    input  logic              ilv_i,
    input  logic              stop_req_i,
    output logic              valid_o,
    output logic              last_o,
    output logic [PAIR_W-1:0] pair_o,
    output logic [COL_W-1:0]  base_o,
    output logic [1:0]        code_o,
    output logic              ilv_o
);
    typedef struct packed {
        logic              active;
        logic              stop;
        logic [PAIR_W-1:0] pair;
        logic [COL_W-1:0]  base;
        logic [1:0]        code;
        logic              ilv;
    } st_t;

    st_t st_d, st_q;

    logic [PAIR_W:0]   pairs_wide;
    logic [PAIR_W-1:0] final_pair;
    logic              at_last;
    logic              take_start;

    always_comb begin
        // pairs per burst is 2^code; index of the final pair is one less
        pairs_wide = (PAIR_W+1)'(1) << bl_code_sel(st_q.code);
        final_pair = PAIR_W'(pairs_wide - (PAIR_W+1)'(1));
        at_last    = st_q.active && ((st_q.pair == final_pair) || st_q.stop);
        take_start = start_i && (!st_q.active || at_last);

        st_d = st_q;
        if (st_q.active) begin
            if (at_last) begin
                st_d.active = 1'b0;
                st_d.stop   = 1'b0;
            end else begin
                st_d.pair = st_q.pair + PAIR_W'(1);
                st_d.stop = stop_req_i;
            end
        end
        if (take_start) begin
            st_d.active = 1'b1;
            st_d.stop   = 1'b0;
            st_d.pair   = '0;
            st_d.base   = start_col_i;
            st_d.code   = bl_code_i;
            st_d.ilv    = ilv_i;
        end
    end

    function automatic int unsigned bl_code_sel(input logic [1:0] c);
        return int'(c);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.active;
    assign last_o  = at_last;
    assign pair_o  = st_q.pair;
    assign base_o  = st_q.base;
    assign code_o  = st_q.code;
    assign ilv_o   = st_q.ilv;
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
    parameter int COL_W      = 10,
    parameter int MAX_BL_LOG = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [1:0]       bl_code_i,
    input  logic             ilv_i,
    input  logic             bst_i,
    input  logic             pre_i,
    output logic [COL_W-1:0] col_even_o,
    output logic [COL_W-1:0] col_odd_o,
    output logic             valid_o,
    output logic             last_o
);
    localparam int BEAT_W = MAX_BL_LOG;
    localparam int PAIR_W = MAX_BL_LOG - 1;
    localparam int NBEAT  = 2;   // beats per clock (prefetch width)

    logic [PAIR_W-1:0]           pair;
    logic [COL_W-1:0]            base;
    logic [1:0]                  code;
    logic                        ilv_q;
    logic [NBEAT-1:0][COL_W-1:0] cols;

    bsq_ctrl #(
        .COL_W  (COL_W),
        .PAIR_W (PAIR_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .bl_code_i   (bl_code_i),
        .ilv_i       (ilv_i),
        .stop_req_i  (bst_i | pre_i),
        .valid_o     (valid_o),
        .last_o      (last_o),
        .pair_o      (pair),
        .base_o      (base),
        .code_o      (code),
        .ilv_o       (ilv_q)
    );

    for (genvar g = 0; g < NBEAT; g++) begin : g_beat
        bsq_beat_addr #(
            .COL_W  (COL_W),
            .BEAT_W (BEAT_W)
        ) u_addr (
            .base_i (base),
            .code_i (code),
            .ilv_i  (ilv_q),
            .beat_i ({pair, 1'(g)}),
            .col_o  (cols[g])
        );
    end

    assign col_even_o = cols[0];
    assign col_odd_o  = cols[1];
endmodule

// File: rtl/bsq_checker.sv
module bsq_checker #(
    parameter int COL_W      = 10,
    parameter int MAX_BL_LOG = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             bst_i,
    input logic             pre_i,
    input logic [COL_W-1:0] col_even_o,
    input logic [COL_W-1:0] col_odd_o,
    input logic             valid_o,
    input logic             last_o
);
    p_last_needs_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    p_hold_until_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !last_o |=> valid_o);

    p_drop_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && last_o && !start_i |=> !valid_o);

    p_open_from_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o && start_i |=> valid_o);

    p_idle_stays_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o && !start_i |=> !valid_o);

    p_early_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !last_o && (bst_i || pre_i) |=> valid_o && last_o);

    p_chain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && last_o && start_i |=> valid_o);

    p_upper_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> col_even_o[COL_W-1:MAX_BL_LOG] == col_odd_o[COL_W-1:MAX_BL_LOG]);
endmodule

bind burst_col_seq bsq_checker #(
    .COL_W      (COL_W),
    .MAX_BL_LOG (MAX_BL_LOG)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .bst_i      (bst_i),
    .pre_i      (pre_i),
    .col_even_o (col_even_o),
    .col_odd_o  (col_odd_o),
    .valid_o    (valid_o),
    .last_o     (last_o)
);

// File: tb/burst_col_seq_tb.sv
`timescale 1ns/1ps
module burst_col_seq_tb;
    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [1:0]       bl_code_i = '0;
    logic             ilv_i = 1'b0;
    logic             bst_i = 1'b0;
    logic             pre_i = 1'b0;
    logic [COL_W-1:0] col_even_o, col_odd_o;
    logic             valid_o, last_o;

    always #2.5 clk = ~clk;

    burst_col_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .bl_code_i(bl_code_i), .ilv_i(ilv_i), .bst_i(bst_i), .pre_i(pre_i),
        .col_even_o(col_even_o), .col_odd_o(col_odd_o),
        .valid_o(valid_o), .last_o(last_o)
    );

    typedef struct {
        logic [COL_W-1:0] ev;
        logic [COL_W-1:0] od;
        logic             lst;
        string            tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   mon_on = 1'b0;
    bit   done = 1'b0;

    function automatic logic [COL_W-1:0] ref_col(input logic [COL_W-1:0] s,
                                                 input int bl, input bit ilv,
                                                 input int i);
        int lo;
        int hi;
        hi = int'(s) - (int'(s) % bl);
        if (ilv) lo = (int'(s) % bl) ^ i;
        else     lo = ((int'(s) % bl) + i) % bl;
        return COL_W'(hi + lo);
    endfunction

    // Drive one burst starting at the current post-negedge point; returns
    // while its final pair is presented. term_at / ign_at: pair index
    // during which stop / stray start is driven (-1: none). use_pre picks
    // precharge instead of burst-stop.
    task automatic burst(input logic [COL_W-1:0] s, input logic [1:0] code,
                         input bit ilv, input int term_at, input bit use_pre,
                         input int ign_at, input string tag);
        int bl;
        int np;
        exp_t e;
        bl = 2 << code;
        np = (term_at >= 0) ? term_at + 2 : bl / 2;
        for (int p = 0; p < np; p++) begin
            e.ev  = ref_col(s, bl, ilv, 2 * p);
            e.od  = ref_col(s, bl, ilv, 2 * p + 1);
            e.lst = (p == np - 1);
            e.tag = (p == 0) ? {tag, " R2"} : tag;
            exp_q.push_back(e);
        end
        start_i = 1'b1; start_col_i = s; bl_code_i = code; ilv_i = ilv;
        @(negedge clk); #1;
        start_i = 1'b0;
        // scramble captured fields so a design that does not hold them fails (R6)
        start_col_i = ~s; bl_code_i = ~code; ilv_i = ~ilv;
        for (int k = 0; k < np - 1; k++) begin
            bst_i   = (k == term_at) && !use_pre;
            pre_i   = (k == term_at) && use_pre;
            start_i = (k == ign_at);
            @(negedge clk); #1;
        end
        bst_i = 1'b0; pre_i = 1'b0; start_i = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk); #1;
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (mon_on) begin
            if (last_o && !valid_o) begin
                n_chk++; n_bad++;
                $display("FAIL R11: last_o=%0b valid_o=%0b, expected last_o=0", last_o, valid_o);
            end
            if (valid_o) begin
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R8/R10: valid_o=1 col=%0h/%0h, expected valid_o=0",
                             col_even_o, col_odd_o);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (col_even_o !== e.ev || col_odd_o !== e.od || last_o !== e.lst) begin
                        n_bad++;
                        $display("FAIL %s: got %0h/%0h last=%0b, expected %0h/%0h last=%0b",
                                 e.tag, col_even_o, col_odd_o, last_o, e.ev, e.od, e.lst);
                    end
                end
            end else if (exp_q.size() != 0) begin
                n_chk++; n_bad++;
                $display("FAIL %s: valid_o=0, expected pair %0h/%0h",
                         exp_q[0].tag, exp_q[0].ev, exp_q[0].od);
            end
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        n_chk++;
        if (valid_o !== 1'b0 || last_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: valid=%0b last=%0b in reset, expected 0/0", valid_o, last_o);
        end
        #1 rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (valid_o !== 1'b0 || last_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: valid=%0b last=%0b after reset, expected 0/0", valid_o, last_o);
        end
        #1 mon_on = 1'b1;

        // R3/R6: sequential at every length, unaligned starts
        burst(10'h201, 2'd0, 1'b0, -1, 1'b0, -1, "R3 R6 seq BL2"); idle(1);
        burst(10'h0A3, 2'd1, 1'b0, -1, 1'b0, -1, "R3 R6 seq BL4"); idle(2);
        burst(10'h1F5, 2'd2, 1'b0, -1, 1'b0, -1, "R3 R5 seq BL8"); idle(1);
        burst(10'h3FD, 2'd3, 1'b0, -1, 1'b0, -1, "R3 R5 seq BL16"); idle(1);
        // R4: interleaved at every length
        burst(10'h155, 2'd0, 1'b1, -1, 1'b0, -1, "R4 ilv BL2"); idle(1);
        burst(10'h2C6, 2'd1, 1'b1, -1, 1'b0, -1, "R4 ilv BL4"); idle(1);
        burst(10'h07B, 2'd2, 1'b1, -1, 1'b0, -1, "R4 ilv BL8"); idle(1);
        burst(10'h3A9, 2'd3, 1'b1, -1, 1'b0, -1, "R4 ilv BL16"); idle(1);
        // R9: back-to-back chain, mixed lengths and modes
        burst(10'h010, 2'd1, 1'b0, -1, 1'b0, -1, "R9 chain a");
        burst(10'h123, 2'd2, 1'b1, -1, 1'b0, -1, "R9 chain b");
        burst(10'h37F, 2'd0, 1'b0, -1, 1'b0, -1, "R9 chain c"); idle(2);
        // R7: early stop by burst-stop and by precharge
        burst(10'h046, 2'd3, 1'b0, 2, 1'b0, -1, "R7 bst"); idle(1);
        burst(10'h2E1, 2'd2, 1'b1, 0, 1'b1, -1, "R7 pre"); idle(1);
        // R9 after an early stop
        burst(10'h100, 2'd3, 1'b1, 4, 1'b0, -1, "R7 R9 stop then chain");
        burst(10'h0FF, 2'd1, 1'b0, -1, 1'b0, -1, "R9 after stop"); idle(1);
        // R8: stray start mid-burst is dropped
        burst(10'h1C2, 2'd3, 1'b0, -1, 1'b0, 3, "R8 ignored start"); idle(1);
        burst(10'h333, 2'd2, 1'b1, -1, 1'b0, 0, "R8 ignored start ilv"); idle(1);
        // R10: stop/precharge while idle
        bst_i = 1'b1; idle(2); bst_i = 1'b0;
        pre_i = 1'b1; idle(2); pre_i = 1'b0;
        idle(3);

        n_chk++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R5: %0d pairs never produced, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule